// File: doc/BRIEF.md
# Latched Two-Byte DAC Code Register

This block sits between a byte-wide write bus and one 12-bit digital-to-analog converter channel. Software delivers each sample as two bytes at two addresses. The low byte only fills a staging register. The high byte completes the sample, so the 12-bit code presented to the converter changes in one step and never shows a half-updated value. To update at full resolution, software writes the low byte and then the high byte. When only the upper bits matter, a single high-byte write is enough and reuses whatever low byte was staged last.

A control byte at a third address sets an output-enable bit and a 3-bit justification format. The format selects which 12 bits of the combined 16-bit word {high, low} form the code. Right-justified, shifted by one, two or three places, and fully left-justified layouts are available. Each high-byte write raises a one-cycle update strobe together with the new code. The converter can use this strobe to start settling.

Top module: `dacreg_latch`

## Requirements
- R1: After reset, dac_code is 0, dac_update is 0, dac_oe is 0, the format is 000 and the staged low byte is 0x00.
- R2: A write to address 0 (low byte) changes none of dac_code, dac_update or dac_oe. It only replaces the staged byte.
- R3: A write to address 1 (high byte) makes the new code visible on dac_code from the clock edge that takes the write. dac_update is high for exactly the cycle after each such edge. dac_code changes at no other time.
- R4: Format 000 takes code = word[11:0], where word = {high byte, staged low byte}. Code bits 11..8 come from high-byte bits 3..0, and bits 7..0 come from the low byte.
- R5: Formats 001 and 011 take code = word[12:1] and word[14:3] respectively.
- R6: Format 010 takes code = word[13:2], which is the format-000 layout moved two places toward the top.
- R7: Formats 100 through 111 take code = word[15:4]. Code bits 11..4 are the high byte, and bits 3..0 are low-byte bits 7..4.
- R8: Word bits that fall outside the selected 12-bit field have no effect on dac_code.
- R9: A high-byte write that has no new low-byte write before it combines with the last staged low byte.
- R10: Address 2 is the control byte. Bit 0 drives dac_oe, bits 3..1 set the format, and bits 7..4 are ignored. Writes to address 3 change nothing.
- R11: A control write leaves dac_code unchanged and raises no update strobe. A new format applies from the next high-byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 2 | Write address: 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data byte |
| dac_code | output | 12 | Code held for the converter |
| dac_update | output | 1 | One-cycle pulse when dac_code loads |
| dac_oe | output | 1 | Converter output enable |

## Verification
The assertions check, on every cycle, the rules that do not depend on data. The code may move only together with the update strobe. The strobe must follow a high-byte write. Low-byte and control writes must neither move the code nor raise the strobe, and the enable may change only after a control write. Which bits land where, for each of the eight formats, can only be shown by the bench. It sweeps every high byte against several low-byte patterns in every format and compares each result with a bit field computed from the 16-bit word. The bench also covers reuse of a stale staged byte, the reset value of the staging register, and the ignored control bits and address.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    // Width of the justification format field
    localparam int FMT_W = 3;

    // Which register a bus write targets
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_CTL  = 2'd3
    } sel_e;

    // Shift of the 12-bit field inside the 16-bit word for a format code:
    // the top bit set means fully left-justified, otherwise the low bits
    // give the shift, clamped to what the word allows.
    function automatic int fmt_shift(input logic [FMT_W-1:0] f, input int max_s);
        int s;
        if (f[FMT_W-1]) s = max_s;
        else            s = int'(f[FMT_W-2:0]);
        if (s > max_s) s = max_s;
        return s;
    endfunction

endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int LO_ADDR  = 0,
    parameter int HI_ADDR  = 1,
    parameter int CTL_ADDR = 2
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    always_comb begin
        sel = SEL_NONE;
        if (we) begin
            if      (addr == LO_A)  sel = SEL_LO;
            else if (addr == HI_A)  sel = SEL_HI;
            else if (addr == CTL_A) sel = SEL_CTL;
        end
    end
endmodule

// File: rtl/dacreg_justify.sv
module dacreg_justify
    import dacreg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CODE_W = 12
) (
    input  logic [FMT_W-1:0]  fmt,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    output logic [CODE_W-1:0] code
);
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int MAX_SHIFT = WORD_W - CODE_W;

    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] cand [0:MAX_SHIFT];

    assign word = {hi, lo};

    // One candidate field per legal shift
    for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_cand
        assign cand[g] = word[g +: CODE_W];
    end

    always_comb begin : p_pick
        int sh;
        sh   = fmt_shift(fmt, MAX_SHIFT);
        code = '0;
        for (int s = 0; s <= MAX_SHIFT; s++) begin
            if (s == sh) code = cand[s];
        end
    end
endmodule

// File: rtl/dacreg_latch.sv
module dacreg_latch
    import dacreg_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int BYTE_W   = 8,
    parameter int CODE_W   = 12,
    parameter int LO_ADDR  = 0,
    parameter int HI_ADDR  = 1,
    parameter int CTL_ADDR = 2,
    parameter int EN_BIT   = 0,
    parameter int FMT_LSB  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_update,
    output logic              dac_oe
);
    typedef struct packed {
        logic [BYTE_W-1:0] stage;
        logic [CODE_W-1:0] code;
        logic              upd;
        logic              en;
        logic [FMT_W-1:0]  fmt;
    } state_t;

    state_t            st_d, st_q;
    sel_e              sel;
    logic [CODE_W-1:0] just_code;

    dacreg_decode #(
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR),
        .CTL_ADDR(CTL_ADDR)
    ) u_decode (
        .we  (bus_we),
        .addr(bus_addr),
        .sel (sel)
    );

    // The incoming byte is the high half; the staged byte is the low half
    dacreg_justify #(
        .BYTE_W(BYTE_W),
        .CODE_W(CODE_W)
    ) u_justify (
        .fmt (st_q.fmt),
        .hi  (bus_wdata),
        .lo  (st_q.stage),
        .code(just_code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        unique case (sel)
            SEL_LO:  st_d.stage = bus_wdata;
            SEL_HI: begin
                st_d.code = just_code;
                st_d.upd  = 1'b1;
            end
            SEL_CTL: begin
                st_d.en  = bus_wdata[EN_BIT];
                st_d.fmt = bus_wdata[FMT_LSB +: FMT_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_code   = st_q.code;
    assign dac_update = st_q.upd;
    assign dac_oe     = st_q.en;
endmodule

// File: rtl/dacreg_latch_chk.sv
module dacreg_latch_chk #(
    parameter int ADDR_W   = 2,
    parameter int CODE_W   = 12,
    parameter int LO_ADDR  = 0,
    parameter int HI_ADDR  = 1,
    parameter int CTL_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_update,
    input logic              dac_oe
);
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    a_r2_lo_write_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == LO_A) |=> ($stable(dac_code) && !dac_update));

    a_r3_code_moves_only_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> dac_update);

    a_r3_update_needs_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |-> $past(bus_we && bus_addr == HI_A));

    a_r10_oe_moves_only_on_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_oe) |-> $past(bus_we && bus_addr == CTL_A));

    a_r11_ctl_write_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTL_A) |=> !dac_update);
endmodule

bind dacreg_latch dacreg_latch_chk #(
    .ADDR_W  (ADDR_W),
    .CODE_W  (CODE_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR),
    .CTL_ADDR(CTL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .dac_code  (dac_code),
    .dac_update(dac_update),
    .dac_oe    (dac_oe)
);

// File: tb/dacreg_latch_tb.sv
`timescale 1ns/1ps
module dacreg_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [11:0] dac_code;
    logic        dac_update;
    logic        dac_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dacreg_latch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dac_code  (dac_code),
        .dac_update(dac_update),
        .dac_oe    (dac_oe)
    );

    function automatic logic [11:0] exp_code(input logic [7:0] hi, input logic [7:0] lo,
                                             input logic [2:0] fmt);
        int word;
        int sh;
        word = {16'd0, hi, lo};
        sh   = fmt[2] ? 4 : int'(fmt[1:0]);
        return 12'((word >> sh) & 32'hFFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one write; on return the edge has taken it and outputs are settled
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle();
        chk("R1 code", dac_code, 0);
        chk("R1 update", dac_update, 0);
        chk("R1 oe", dac_oe, 0);

        // R1: staged byte and format are cleared by reset
        wr(2'd1, 8'hFF);
        chk("R1 staged low cleared", dac_code, 12'hF00);
        chk("R3 update pulse", dac_update, 1);
        idle();
        chk("R3 update one cycle", dac_update, 0);

        // R2: low-byte write is invisible
        wr(2'd0, 8'h34);
        chk("R2 code kept", dac_code, 12'hF00);
        chk("R2 no update", dac_update, 0);
        chk("R2 oe kept", dac_oe, 0);
        idle();
        chk("R2 code still kept", dac_code, 12'hF00);

        wr(2'd1, 8'h02);
        chk("R3 code loads", dac_code, 12'h234);
        // R9: no new low byte, staged one is reused
        wr(2'd1, 8'h07);
        chk("R9 stale low reused", dac_code, 12'h734);
        chk("R3 update on second write", dac_update, 1);

        // R10, R11: control register
        wr(2'd2, 8'hF1);
        chk("R10 enable set, upper bits ignored", dac_oe, 1);
        chk("R11 ctl keeps code", dac_code, 12'h734);
        chk("R11 ctl no update", dac_update, 0);
        wr(2'd3, 8'hFF);
        chk("R10 unused address oe", dac_oe, 1);
        chk("R10 unused address code", dac_code, 12'h734);
        chk("R10 unused address no update", dac_update, 0);
        wr(2'd2, 8'h08);
        chk("R10 enable cleared", dac_oe, 0);
        chk("R11 format change keeps code", dac_code, 12'h734);
        wr(2'd1, 8'hAB);
        chk("R11 new format applied on high write", dac_code, exp_code(8'hAB, 8'h34, 3'b100));

        // R3: back-to-back high writes keep the strobe up, then it drops
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h11;
        @(posedge clk); #1;
        bus_wdata = 8'h22;
        chk("R3 first of pair", dac_code, exp_code(8'h11, 8'h34, 3'b100));
        @(posedge clk); #1;
        bus_we = 1'b0;
        chk("R3 second of pair", dac_code, exp_code(8'h22, 8'h34, 3'b100));
        chk("R3 strobe held for pair", dac_update, 1);
        idle();
        chk("R3 strobe drops", dac_update, 0);

        // Sweep: every format, several low patterns, every high byte (R4-R8)
        for (int f = 0; f < 8; f++) begin
            wr(2'd2, {4'hA, 3'(f), 1'b1});
            chk("R10 enable in sweep", dac_oe, 1);
            for (int li = 0; li < 5; li++) begin
                logic [7:0] lo;
                case (li)
                    0: lo = 8'h00;
                    1: lo = 8'hFF;
                    2: lo = 8'hA5;
                    3: lo = 8'h5A;
                    default: lo = 8'h3C;
                endcase
                wr(2'd0, lo);
                for (int h = 0; h < 256; h++) begin
                    wr(2'd1, 8'(h));
                    // R8: stray bits in either byte must not leak in
                    if (f == 0)                chk("R4 R8 format 000", dac_code, exp_code(8'(h), lo, 3'(f)));
                    else if (f == 1 || f == 3) chk("R5 R8 format 001/011", dac_code, exp_code(8'(h), lo, 3'(f)));
                    else if (f == 2)           chk("R6 R8 format 010", dac_code, exp_code(8'(h), lo, 3'(f)));
                    else                       chk("R7 R8 format 1xx", dac_code, exp_code(8'(h), lo, 3'(f)));
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule